// File: doc/BRIEF.md
# Frame-Boundary Gated Stream Stage

This block sits in a pixel stream between a packet source and a packet sink. It forwards beats unchanged through one registered output stage. Both sides use valid/ready flow control, and start-of-packet and end-of-packet flags mark where packets begin and end. A small register slave holds a run-enable flag that the host sets and clears, plus a read-only running indication. The stage only pauses or resumes image data at the head of an image packet. This means downstream parameters can be reprogrammed between frames without tearing a frame.

The packet kind comes from the low nibble of the head beat. A value of 0 marks image data and 15 marks control information. Non-image packets always flow, so frame-size announcements still reach the next stage while image data is held back. After reset the run-enable flag is unknown on real hardware, so the block forces it to zero for a fixed settling window. The host then has to enable the stage on purpose.

Top module: `pkt_gate_stage`

## Requirements
- R1: After reset, out_valid is 0, status_run is 0, and a read of register 0 returns 0.
- R2: For INIT_CYCLES (default 8) clocks after reset, the hardware holds the run-enable flag at 0. A host write of 1 during that window has no effect, and register 0 reads back 0 afterwards.
- R3: Register index 0 bit 0 is the run-enable flag (read/write). Register index 1 bit 0 mirrors status_run. All other bits, and register indices 2 and 3, read as 0. csr_rvalid pulses one clock after csr_rd, with csr_rdata valid alongside it.
- R4: Host writes to register index 1 are ignored. status_run and the gating are unchanged by them.
- R5: With run-enable at 0, an image packet (head beat with in_sop=1 and in_data[3:0]=0) arriving at a packet boundary is held. in_ready stays 0 and no beat of it appears at the output.
- R6: Packets whose head nibble is not 0 (control packets with code 15, or any other code) are accepted and forwarded whatever the run-enable value.
- R7: If run-enable is cleared while an image packet is in flight, that packet completes in full. The next image packet is then held.
- R8: Once run-enable is written to 1, a pending image head is accepted within 3 clocks, provided the output register has room.
- R9: status_run is 1 while image data is allowed to flow and 0 while halted. It changes only at packet boundaries, and it is 1 in the clock after an image head is accepted.
- R10: Every accepted beat leaves in order, with data, in_sop and in_eop unchanged. While out_valid=1 and out_ready=0, the output beat is held stable.
- R11: When the output register is full and out_ready is 0, in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Register index |
| csr_wdata | input | CSR_W | Write data |
| csr_rdata | output | CSR_W | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read data valid, one clock after csr_rd |
| status_run | output | 1 | Running indication |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Stage accepts the upstream beat |
| in_data | input | DATA_W | Upstream beat data; low nibble of head beat is packet kind |
| in_sop | input | 1 | Upstream start of packet |
| in_eop | input | 1 | Upstream end of packet |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream sink accepts |
| out_data | output | DATA_W | Downstream beat data |
| out_sop | output | 1 | Downstream start of packet |
| out_eop | output | 1 | Downstream end of packet |

## Verification
The stream is exercised in four regimes. A sink that is always ready shows single-cycle throughput. A sink ready one clock in three lets a run-enable change land inside a packet, which separates a mid-frame stop from a boundary stop. A sink that alternates ready exercises back-to-back mixed packets, including single-beat image packets. A sink stalled entirely shows that the output holds its beat and back-pressure reaches upstream. Control and unknown-kind packets are sent while halted, to tell kind-based gating apart from a blanket stall. Register writes within the settling window, and writes to the status index, show that those accesses change nothing.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;
  localparam int KIND_W    = 4;
  localparam int KIND_IMG  = 0;
  localparam int KIND_CTRL = 15;
  localparam int IDX_RUN   = 0;
  localparam int IDX_STAT  = 1;

  typedef enum logic [1:0] {
    GS_GAP  = 2'd0,
    GS_IMG  = 2'd1,
    GS_AUX  = 2'd2
  } gate_st_t;
endpackage

// File: rtl/pkt_gate_regs.sv
module pkt_gate_regs
  import pkt_gate_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CSR_W       = 32,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CSR_W-1:0]  wdata,
  input  logic              run_state,
  output logic              run_en,
  output logic [CSR_W-1:0]  rdata,
  output logic              rvalid
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] settle_cnt;
  logic             settled;

  assign settled = (settle_cnt == CNT_W'(INIT_CYCLES));

  // settling window counter
  always_ff @(posedge clk) begin
    if (rst)
      settle_cnt <= '0;
    else if (!settled)
      settle_cnt <= settle_cnt + 1'b1;
  end

  // run-enable flag: forced low until the window ends
  always_ff @(posedge clk) begin
    if (rst || !settled)
      run_en <= 1'b0;
    else if (wr && addr == ADDR_W'(IDX_RUN))
      run_en <= wdata[0];
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)
      rvalid <= 1'b0;
    else
      rvalid <= rd;
  end

  always_ff @(posedge clk) begin
    if (rd) begin
      rdata <= '0;
      if (addr == ADDR_W'(IDX_RUN))
        rdata[0] <= run_en;
      else if (addr == ADDR_W'(IDX_STAT))
        rdata[0] <= run_state;
    end
  end
endmodule

// File: rtl/pkt_gate_fsm.sv
module pkt_gate_fsm
  import pkt_gate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              head_valid,
  input  logic [DATA_W-1:0] head_data,
  input  logic              beat_eop,
  input  logic              fire,
  output logic              allow,
  output logic              running
);
  gate_st_t st;
  logic     head_img;

  assign head_img = (head_data[KIND_W-1:0] == KIND_W'(KIND_IMG));

  // an image head at a gap passes only when enabled; all else passes
  always_comb begin
    allow = 1'b1;
    if (st == GS_GAP && head_valid && head_img)
      allow = run_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= GS_GAP;
    end else if (fire) begin
      unique case (st)
        GS_GAP:  if (!beat_eop) st <= head_img ? GS_IMG : GS_AUX;
        GS_IMG,
        GS_AUX:  if (beat_eop) st <= GS_GAP;
        default: st <= GS_GAP;
      endcase
    end
  end

  // running indication follows the enable only between packets
  always_ff @(posedge clk) begin
    if (rst)
      running <= 1'b0;
    else if (st == GS_GAP)
      running <= run_en;
  end
endmodule

// File: rtl/pkt_gate_obuf.sv
module pkt_gate_obuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_sop,
  input  logic              d_eop,
  input  logic              q_ready,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_sop,
  output logic              q_eop,
  output logic              room
);
  assign room = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (rst)
      q_valid <= 1'b0;
    else if (load)
      q_valid <= 1'b1;
    else if (q_ready)
      q_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_data <= d_data;
      q_sop  <= d_sop;
      q_eop  <= d_eop;
    end
  end
endmodule

// File: rtl/pkt_gate_stage.sv
module pkt_gate_stage
  import pkt_gate_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int CSR_W       = 32,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              csr_rvalid,
  output logic              status_run,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  logic run_en;
  logic allow;
  logic room;
  logic fire;

  assign in_ready = allow && room;
  assign fire     = in_valid && in_ready;

  pkt_gate_regs #(
    .ADDR_W(ADDR_W), .CSR_W(CSR_W), .INIT_CYCLES(INIT_CYCLES)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(csr_wr), .rd(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .run_state(status_run), .run_en(run_en),
    .rdata(csr_rdata), .rvalid(csr_rvalid)
  );

  pkt_gate_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .run_en(run_en), .head_valid(in_valid),
    .head_data(in_data), .beat_eop(in_eop), .fire(fire),
    .allow(allow), .running(status_run)
  );

  pkt_gate_obuf #(.DATA_W(DATA_W)) u_obuf (
    .clk(clk), .rst(rst), .load(fire), .d_data(in_data), .d_sop(in_sop),
    .d_eop(in_eop), .q_ready(out_ready), .q_valid(out_valid),
    .q_data(out_data), .q_sop(out_sop), .q_eop(out_eop), .room(room)
  );
endmodule

// File: rtl/pkt_gate_chk.sv
module pkt_gate_chk
  import pkt_gate_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CSR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [CSR_W-1:0]  csr_rdata,
  input logic              csr_rvalid,
  input logic              status_run,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_sop,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic in_pkt;
  logic is_img, is_ctrl;

  assign is_img  = (in_data[KIND_W-1:0] == KIND_W'(KIND_IMG));
  assign is_ctrl = (in_data[KIND_W-1:0] == KIND_W'(KIND_CTRL));

  always_ff @(posedge clk) begin
    if (rst)
      in_pkt <= 1'b0;
    else if (in_valid && in_ready)
      in_pkt <= !in_eop;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R11

  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
    !in_pkt && in_valid && in_sop && is_ctrl && (!out_valid || out_ready)
      |-> in_ready); // R6

  AST_IMG_START_RUN: assert property (@(posedge clk) disable iff (rst)
    !in_pkt && in_valid && in_ready && in_sop && is_img |=> status_run); // R9

  AST_STATUS_MIDPKT: assert property (@(posedge clk) disable iff (rst)
    in_pkt |=> status_run == $past(status_run)); // R9

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    csr_rvalid |-> csr_rdata[CSR_W-1:1] == '0); // R3
endmodule

bind pkt_gate_stage pkt_gate_chk #(.DATA_W(DATA_W), .CSR_W(CSR_W)) u_chk (
  .clk(clk), .rst(rst), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid),
  .status_run(status_run), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/pkt_gate_stage_test.sv
module pkt_gate_stage_test;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csr_wr = 1'b0, csr_rd = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [CW-1:0] csr_wdata = '0;
  logic [CW-1:0] csr_rdata;
  logic          csr_rvalid;
  logic          status_run;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic          out_ready = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int accepted = 0;
  int rmode = 0;
  int tcnt = 0;
  int cyc = 0;
  logic [DW+1:0] sb[$];

  always #10 clk = ~clk;

  pkt_gate_stage uut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_rvalid(csr_rvalid), .status_run(status_run),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tcnt <= tcnt + 1;
    case (rmode)
      0: out_ready <= 1'b1;
      1: out_ready <= (tcnt % 3 == 0);
      2: out_ready <= tcnt[0];
      default: out_ready <= 1'b0;
    endcase
  end

  // monitor: pop and compare every beat leaving the stage (R10)
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check("R10 unexpected beat", {14'd0, out_sop, out_eop, out_data}, 32'hdead);
      end else begin
        check("R10 beat", {14'd0, out_sop, out_eop, out_data}, {14'd0, sb.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic csr_write(input int idx, input logic [31:0] v);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = AW'(idx); csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input int idx, output logic [31:0] v);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = AW'(idx);
    @(negedge clk);
    csr_rd = 1'b0;
    check("R3 rvalid", {31'd0, csr_rvalid}, 32'd1);
    v = csr_rdata;
  endtask

  task automatic send_pkt(input int kind, input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] d;
      d = (i == 0) ? {tag[11:0], kind[3:0]} : DW'(tag * 64 + i);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = (i == 0); in_eop = (i == len - 1);
      forever begin
        #1;
        if (in_ready) begin
          sb.push_back({in_sop, in_eop, in_data});
          accepted++;
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    int snap;
    rmode = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 status_run", {31'd0, status_run}, 32'd0);
    // R2 write during settling window is lost
    csr_write(0, 32'd1);
    csr_read(0, rv);
    check("R1 R2 run flag after early write", rv, 32'd0);
    repeat (12) @(negedge clk);
    csr_read(0, rv);
    check("R2 run flag after window", rv, 32'd0);

    // R6 non-image packets flow while halted
    send_pkt(15, 4, 1);
    send_pkt(5, 2, 2);
    drain();
    check("R6 status stays low", {31'd0, status_run}, 32'd0);

    // R5 image packet held while halted
    snap = accepted;
    fork send_pkt(0, 5, 3); join_none
    repeat (20) @(negedge clk);
    check("R5 nothing accepted", accepted, snap);
    check("R5 in_ready low", {31'd0, in_ready}, 32'd0);
    check("R5 out_valid low", {31'd0, out_valid}, 32'd0);
    // R4 status writes ignored
    csr_write(1, 32'hffff_ffff);
    repeat (3) @(negedge clk);
    csr_read(1, rv);
    check("R4 status after write", rv, 32'd0);
    check("R4 still held", accepted, snap);
    // R8 resume
    csr_write(0, 32'd1);
    repeat (2) @(negedge clk);
    check("R8 head accepted", {31'd0, accepted > snap}, 32'd1);
    check("R8 R9 status high", {31'd0, status_run}, 32'd1);
    wait fork;
    drain();
    // R3 register map
    csr_read(0, rv); check("R3 run flag", rv, 32'd1);
    csr_read(1, rv); check("R3 status reg", rv, 32'd1);
    csr_read(2, rv); check("R3 idx2 zero", rv, 32'd0);
    csr_read(3, rv); check("R3 idx3 zero", rv, 32'd0);

    // R7 stop requested mid-frame
    rmode = 1;
    snap = accepted;
    fork begin send_pkt(0, 8, 4); send_pkt(0, 3, 5); end join_none
    repeat (4) @(negedge clk);
    csr_write(0, 32'd0);
    check("R9 status high mid-frame", {31'd0, status_run}, 32'd1);
    while (accepted < snap + 8) @(negedge clk);
    repeat (15) @(negedge clk);
    check("R7 first packet complete, next held", accepted, snap + 8);
    check("R7 R9 status low at gap", {31'd0, status_run}, 32'd0);
    csr_write(0, 32'd1);
    wait fork;
    drain();

    // R11 stalled sink
    rmode = 3;
    repeat (2) @(negedge clk);
    snap = accepted;
    fork send_pkt(0, 3, 6); join_none
    repeat (6) @(negedge clk);
    check("R11 one beat taken", accepted, snap + 1);
    check("R11 in_ready low", {31'd0, in_ready}, 32'd0);
    check("R10 held beat", {16'd0, out_data}, {16'd0, 12'd6, 4'd0});
    rmode = 0;
    wait fork;
    drain();

    // R10 mixed traffic with alternating sink
    rmode = 2;
    send_pkt(0, 1, 7);
    send_pkt(15, 3, 8);
    send_pkt(0, 6, 9);
    send_pkt(9, 1, 10);
    send_pkt(0, 2, 11);
    drain();
    check("R10 scoreboard empty", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule